// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries inside an Ethernet switch. Each entry pairs a 12-bit VLAN identifier with a mask of member ports. Software drives the table through two registers on a simple register bus: a data register that holds the member mask to be loaded, and a command register that carries an opcode, a VID, a port number and an active bit. Writing the command register with the active bit set starts a command. The engine runs it over one or more clock cycles and then drops the active bit, which software polls to learn that the command has finished.

Five opcodes are provided: no-op, flush of the whole table, load (insert or update), purge of one VID, and removal of one port from every entry. A load that finds neither a matching VID nor a free slot raises a full flag and leaves the table as it was. Forwarding logic reads the table through a separate lookup port that returns the member mask and a hit flag for a requested VID, registered once.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the table holds no valid entry, both registers read back as zero, and every lookup misses.
- R2: A command write with bit 3 set, made while idle, is accepted. The command register then reads back its fields at fixed places: opcode in bits 2:0 (0 no-op, 1 flush, 2 load, 3 purge, 4 remove port), active in bit 3, full in bit 4, port in bits 11:8, VID in bits 27:16, priority in bits 30:28 and priority enable in bit 31. A command write with bit 3 clear changes nothing.
- R3: While the active bit is set, writes to the command register and to the data register are ignored.
- R4: A load whose VID is not in the table stores a new valid entry with that VID and the data register's mask. A lookup of that VID then reports a hit and that mask.
- R5: A load whose VID matches a valid entry replaces that entry's mask and adds no entry. This works even when the table is full.
- R6: A load with a new VID while all 16 entries are valid sets the full flag (bit 4) and leaves the table unchanged. The next accepted command clears the flag.
- R7: A purge invalidates the entry whose VID matches. A purge of an absent VID changes nothing.
- R8: A flush invalidates every entry over 16 cycles, and the lookup port reports a miss throughout the flush.
- R9: Remove-port clears the named port's bit in the mask of every entry and keeps all entries valid. A port number at or above the port count changes nothing.
- R10: No-op, load, purge and the unused opcodes 5 to 7 hold the active bit for exactly one cycle. Flush and remove-port hold it for 16 cycles. Opcodes 0 and 5 to 7 leave the table untouched.
- R11: The data register reads back the member mask in bits 9:0 and the valid bit in bit 11, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command, 1 data |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 1 | Read source: 0 command, 1 data |
| rd_data | output | 32 | Register read value (combinational) |
| lk_vid | input | 12 | VID to look up |
| lk_hit | output | 1 | Lookup found a valid entry (registered) |
| lk_mask | output | 10 | Member mask of the found entry, zero on a miss |

## Verification
The table is first filled with sixteen distinct VIDs carrying arithmetically derived masks. A seventeenth new VID is then loaded, which tells the full path apart from a silent overwrite. A reload of an existing VID on the full table separates matching from slot allocation. Remove-port is swept over every port number, including two past the port count, and all twenty candidate VIDs are looked up after each step; this exposes a wrong bit, a skipped entry or any change to validity. A flush is observed cycle by cycle on the lookup port, and commands written while the engine is busy are checked through register readback to show that they were dropped.

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  input  logic [11:0]      lk_vid,
  output logic             lk_hit,
  output logic [PORTS-1:0] lk_mask
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
  localparam logic [2:0] OP_NOP = 3'd0, OP_FLUSH = 3'd1, OP_LOAD = 3'd2,
                         OP_PURGE = 3'd3, OP_RMPORT = 3'd4;

  logic [2:0]       op_q;
  logic             busy_q, full_q, pe_q, dval_q;
  logic [3:0]       port_q;
  logic [11:0]      vid_q;
  logic [2:0]       prio_q;
  logic [PORTS-1:0] dmask_q;
  logic [IW-1:0]    idx_q;

  logic [ENTRIES-1:0] ent_val;
  logic [11:0]        ent_vid  [ENTRIES];
  logic [PORTS-1:0]   ent_mask [ENTRIES];

  logic          c_hit, f_any, l_hit;
  logic [IW-1:0] c_idx, f_idx, l_idx;

  always_comb begin
    c_hit = 1'b0; c_idx = '0;
    f_any = 1'b0; f_idx = '0;
    l_hit = 1'b0; l_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_val[i] && ent_vid[i] == vid_q) begin c_hit = 1'b1; c_idx = IW'(i); end
      if (!ent_val[i])                       begin f_any = 1'b1; f_idx = IW'(i); end
      if (ent_val[i] && ent_vid[i] == lk_vid) begin l_hit = 1'b1; l_idx = IW'(i); end
    end
  end

  wire [PORTS-1:0] rm_bit = PORTS'(1) << port_q;
  wire flushing = busy_q && op_q == OP_FLUSH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; busy_q <= 1'b0; full_q <= 1'b0; pe_q <= 1'b0; dval_q <= 1'b0;
      port_q <= '0; vid_q <= '0; prio_q <= '0; dmask_q <= '0; idx_q <= '0;
      ent_val <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vid[i]  <= '0;
        ent_mask[i] <= '0;
      end
      lk_hit <= 1'b0; lk_mask <= '0;
    end else begin
      if (!busy_q) begin
        if (wr_en && wr_sel) begin
          dmask_q <= wr_data[PORTS-1:0];
          dval_q  <= wr_data[11];
        end else if (wr_en && wr_data[3]) begin
          op_q   <= wr_data[2:0];
          port_q <= wr_data[11:8];
          vid_q  <= wr_data[27:16];
          prio_q <= wr_data[30:28];
          pe_q   <= wr_data[31];
          busy_q <= 1'b1;
          full_q <= 1'b0;
          idx_q  <= '0;
        end
      end else begin
        case (op_q)
          OP_FLUSH: begin
            ent_val[idx_q] <= 1'b0;
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) busy_q <= 1'b0;
          end
          OP_LOAD: begin
            if (c_hit) ent_mask[c_idx] <= dmask_q;
            else if (f_any) begin
              ent_val[f_idx]  <= 1'b1;
              ent_vid[f_idx]  <= vid_q;
              ent_mask[f_idx] <= dmask_q;
            end else full_q <= 1'b1;
            busy_q <= 1'b0;
          end
          OP_PURGE: begin
            if (c_hit) ent_val[c_idx] <= 1'b0;
            busy_q <= 1'b0;
          end
          OP_RMPORT: begin
            if (ent_val[idx_q]) ent_mask[idx_q] <= ent_mask[idx_q] & ~rm_bit;
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) busy_q <= 1'b0;
          end
          default: busy_q <= 1'b0;
        endcase
      end
      lk_hit  <= l_hit && !flushing;
      lk_mask <= (l_hit && !flushing) ? ent_mask[l_idx] : '0;
    end
  end

  assign rd_data = rd_sel ? {20'b0, dval_q, 1'b0, 10'(dmask_q)}
                          : {pe_q, prio_q, vid_q, 4'b0, port_q, 3'b0, full_q, busy_q, op_q};

  a_r3_busy_writes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> ($stable(vid_q) && $stable(op_q) && $stable(dmask_q) && $stable(dval_q)));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q != OP_FLUSH && op_q != OP_RMPORT) |=> !busy_q);

  a_r8_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> !lk_hit);

  a_r6_full_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $stable(ent_val));

  a_r4_one_new_entry: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ent_val) <= $countones($past(ent_val)) + 1));

  a_r9_rmport_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_RMPORT) |=> $stable(ent_val));
endmodule

// File: tb/vlan_cmd_engine_test.sv
module vlan_cmd_engine_test;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [11:0] lk_vid = 0;
  logic lk_hit;
  logic [9:0] lk_mask;

  vlan_cmd_engine uut (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
                       .lk_vid, .lk_hit, .lk_mask);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic        mv [16];
  logic [11:0] mvid [16];
  logic [9:0]  mmask [16];
  logic        mfull;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [2:0] op, logic [3:0] port, logic [11:0] vid,
                                      logic [2:0] pr, logic pe, logic act);
    return {pe, pr, vid, 4'b0, port, 3'b0, 1'b0, act, op};
  endfunction

  function automatic logic [11:0] vidf(int i); return 12'(100 + i * 37); endfunction
  function automatic logic [9:0] maskf(int i, int s); return 10'((i * 53 + s * 29 + 17) & 10'h3ff); endfunction

  task automatic bus_wr(logic sel, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0; rd_sel = 0;
    while (rd_data[3] && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  task automatic cmd(logic [2:0] op, logic [3:0] port, logic [11:0] vid, output int cyc);
    bus_wr(0, enc(op, port, vid, 3'd0, 1'b0, 1'b1));
    wait_idle(cyc);
  endtask

  task automatic look(logic [11:0] v, string tag);
    logic eh; logic [9:0] em;
    eh = 0; em = 0;
    for (int i = 0; i < 16; i++) if (mv[i] && mvid[i] == v && !eh) begin eh = 1; em = mmask[i]; end
    @(negedge clk); lk_vid = v;
    @(negedge clk);
    chk(tag, {21'b0, lk_hit, lk_mask}, {21'b0, eh, em});
  endtask

  task automatic look_all(string tag);
    for (int i = 0; i < 20; i++) look(vidf(i), tag);
  endtask

  task automatic do_load(logic [11:0] v, logic [9:0] m, string tag);
    int cyc, f;
    bit hit;
    bus_wr(1, {20'b0, 1'b1, 1'b0, m});
    cmd(3'd2, 4'd0, v, cyc);
    chk({tag, " R10 load cycles"}, cyc, 1);
    hit = 0; f = -1;
    for (int i = 0; i < 16; i++) if (mv[i] && mvid[i] == v) begin mmask[i] = m; hit = 1; end
    if (!hit) begin
      for (int i = 15; i >= 0; i--) if (!mv[i]) f = i;
      if (f >= 0) begin mv[f] = 1; mvid[f] = v; mmask[f] = m; end
    end
    mfull = !hit && f < 0;
    rd_sel = 0;
    chk({tag, " R6 full flag"}, rd_data[4], mfull);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [31:0] e;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mvid[i] = 0; mmask[i] = 0; end
    mfull = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd_sel = 0; chk("R1 cmd reg reset", rd_data, 0);
    rd_sel = 1; #0 chk("R1 data reg reset", rd_data, 0);
    rd_sel = 0;
    look(12'd0, "R1 lookup miss");
    look(vidf(0), "R1 lookup miss");

    bus_wr(1, 32'h0000_0a55);
    rd_sel = 1; #0 chk("R11 data readback", rd_data, 32'h0000_0a55 & 32'h0000_0bff);
    bus_wr(1, 32'hffff_ffff);
    #0 chk("R11 data readback all ones", rd_data, 32'h0000_0bff);
    rd_sel = 0;

    bus_wr(0, enc(3'd2, 4'd3, 12'h123, 3'd1, 1'b1, 1'b0));
    #0 chk("R2 write without active bit", rd_data, 0);
    e = enc(3'd0, 4'd5, 12'habc, 3'd6, 1'b1, 1'b1);
    bus_wr(0, e);
    #0 chk("R2 fields while active", rd_data, e);
    wait_idle(cyc);
    chk("R10 noop cycles", cyc, 1);
    chk("R2 fields after finish", rd_data, e & ~32'h8);
    look_all("R10 noop leaves table");

    for (int i = 0; i < 16; i++) do_load(vidf(i), maskf(i, 0), "R4 fill");
    look_all("R4 lookup after fill");

    do_load(vidf(16), 10'h155, "R6 overflow");
    chk("R6 full set", rd_data[4], 1);
    look_all("R6 table unchanged");

    do_load(vidf(3), 10'h2aa, "R5 overwrite on full table");
    chk("R5 no full on match", rd_data[4], 0);
    look_all("R5 lookup after overwrite");

    cmd(3'd3, 4'd0, vidf(5), cyc);
    chk("R10 purge cycles", cyc, 1);
    for (int i = 0; i < 16; i++) if (mv[i] && mvid[i] == vidf(5)) mv[i] = 0;
    look_all("R7 purge hit");
    cmd(3'd3, 4'd0, 12'd7, cyc);
    look_all("R7 purge absent");
    do_load(vidf(17), 10'h0f0, "R7 slot reused");

    for (int op = 5; op < 8; op++) begin
      cmd(3'(op), 4'd2, vidf(2), cyc);
      chk("R10 unused opcode cycles", cyc, 1);
    end
    look_all("R10 unused opcodes leave table");

    e = enc(3'd4, 4'd15, 12'h0, 3'd0, 1'b0, 1'b1);
    bus_wr(0, e);
    bus_wr(0, enc(3'd1, 4'd1, 12'h777, 3'd2, 1'b0, 1'b1));
    bus_wr(1, 32'h0000_0bff);
    wait_idle(cyc);
    chk("R3 cmd write dropped", rd_data, e & ~32'h8);
    rd_sel = 1; #0 chk("R3 data write dropped", rd_data, {20'b0, 1'b1, 1'b0, 10'h0f0});
    rd_sel = 0;
    look_all("R9 port 15 no effect");

    for (int p = 0; p < 12; p++) begin
      cmd(3'd4, 4'(p), 12'd0, cyc);
      chk("R10 remove port cycles", cyc, 16);
      if (p < 10) for (int i = 0; i < 16; i++) mmask[i][p] = 1'b0;
      look_all("R9 remove port");
    end

    for (int i = 0; i < 16; i++) do_load(vidf(i), maskf(i, 1), "R5 reload");
    look_all("R5 lookup after reload");

    lk_vid = vidf(4);
    bus_wr(0, enc(3'd1, 4'd0, 12'd0, 3'd0, 1'b0, 1'b1));
    cyc = 0;
    while (rd_data[3] && cyc < 200) begin
      @(negedge clk); cyc++;
      chk("R8 miss during flush", lk_hit, 0);
    end
    chk("R10 flush cycles", cyc, 16);
    for (int i = 0; i < 16; i++) mv[i] = 0;
    look_all("R8 all invalid after flush");

    for (int i = 0; i < 16; i++) do_load(vidf(i + 4), maskf(i, 2), "R4 refill after flush");
    look_all("R4 lookup after refill");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule